// File: doc/BRIEF.md
# Branch Trace Capture Recorder

The recorder sits beside a processor core and watches the per-cycle execution trace port. That port carries the executed instruction address as a halved program counter, an enable that qualifies the address, a flag that separates sequential steps from branches, a lockup indicator and a non-instruction-activity flag. When a branch is taken, the recorder writes two 32-bit words to an external circular trace RAM. The first word holds the last sequential address, which is the source of the branch. The second word holds the branch target. Each word is the 31-bit halved address with one marker bit below it.

Two address comparators can gate capture. When the start comparator is enabled, recording stays off until an execute address equals its value. When the stop comparator is enabled, a match ends recording. The write pointer runs inside a power-of-two window placed at a programmable base. In the optional stop-on-full mode, the block stops writing when the window is full and asks the core to halt. A small register port sets up the block and reads it back. Trace words leave through a simple synchronous write port, and everything runs on one clock.

Top module: `brtrace_rec`

## Requirements
- R1: A synchronous active-low reset clears the write offset to 0, turns recording off, and drops `halt_req`. After reset no RAM write happens until the block is armed.
- R2: While recording, a cycle with `ex_addr_en`=1 and `ex_seq`=0 makes two writes in order. The first is the source (the previous qualified address) and the second is the target. Each word is `{addr[30:0], mark}`, and they go to consecutive slots at base+offset.
- R3: A cycle with `ex_addr_en`=0 is ignored. Its address never becomes a source, and its `ex_seq` value causes no record. Cycles with `ex_seq`=1 record nothing.
- R4: While `core_lockup` is 1, no record is made and the address in that cycle is not tracked as a source.
- R5: A branch seen while `core_nonins` is 1 is not recorded. Its target is still tracked and becomes the source of the next record.
- R6: With the start comparator enabled (CTRL bit 1), recording begins after a qualified address equals the start value. A branch landing on the start address is not itself recorded.
- R7: With the stop comparator enabled (CTRL bit 2), recording ends when a qualified address equals the stop value. A branch whose target matches is still recorded. CTRL bit 16 reads back 1 while recording and 0 otherwise.
- R8: The mark bit (bit 0) of the source word is 1 only on the first record after arming or after a start match. It is 0 in every other source word and in every target word.
- R9: The offset steps by one per write and wraps at 2^size, where size is CTRL[8:4] and a value of 0 or above the address width means the whole RAM. The RAM address is base+offset, taken modulo the RAM size.
- R10: With stop-on-full (CTRL bit 3), the write into the last slot of the window is the final write. `halt_req` rises on the next cycle and stays high. With the mode off, writing wraps and `halt_req` stays 0.
- R11: Register map: 0 CTRL (bit 0 arm), 1 start value as a byte address, 2 stop value as a byte address, 3 base, 4 offset (a write loads it). Registers read back what was written. Any CTRL write clears `halt_req` (read back at CTRL bit 17).
- R12: Branches on back-to-back cycles are all recorded in arrival order, for bursts of up to the pair-queue depth plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ex_addr | input | 31 | Executed instruction address, program counter shifted right by one |
| ex_addr_en | input | 1 | Qualifies `ex_addr` for this cycle |
| ex_seq | input | 1 | 1 when the qualified address follows the previous one sequentially |
| core_lockup | input | 1 | Core is in lockup this cycle |
| core_nonins | input | 1 | Core is busy with non-instruction activity |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| ram_we | output | 1 | Trace RAM write enable |
| ram_waddr | output | 10 | Trace RAM word address |
| ram_wdata | output | 32 | Trace word |
| halt_req | output | 1 | Request for the core to enter debug state and halt |

## Verification
A wrong tracked source address shows up at the RAM port in the very first word written after the branch, two cycles after the branch cycle. A pointer that drifts or wraps at the wrong point shows up in `ram_waddr` on the next write, and is also visible at once through an offset read. If the recording-active or first-record state is wrong, whole pairs go missing or the mark bit lands on the wrong source word. Checking the complete list of writes after each scenario exposes this as soon as the scenario drains. A halt flag that is lost or that rises too early appears on `halt_req` one cycle after the last-slot write.

// File: rtl/brtrace_pkg.sv
// Package: shared constants and the captured-pair type of the branch trace
// recorder. Assumes register offsets and CTRL bit positions are fixed by the
// software view described in the brief.
package brtrace_pkg;

    localparam int ADDR_W = 31;
    localparam int WORD_W = 32;
    localparam int SIZE_W = 5;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_START = 3'd1;
    localparam logic [2:0] REG_STOP  = 3'd2;
    localparam logic [2:0] REG_BASE  = 3'd3;
    localparam logic [2:0] REG_PTR   = 3'd4;

    localparam int CB_ARM       = 0;
    localparam int CB_USE_START = 1;
    localparam int CB_USE_STOP  = 2;
    localparam int CB_HOF       = 3;
    localparam int CB_SIZE_LO   = 4;
    localparam int CB_ACTIVE    = 16;
    localparam int CB_HALT      = 17;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              first;
    } pair_t;

endpackage

// File: rtl/brtrace_regs.sv
// Module: configuration registers and read-back mux.
// Holds CTRL fields, both comparator values and the window base, and derives
// the wrap mask from the size field. Assumes one register access per cycle;
// offset storage lives in the writer, so a PTR write is only forwarded.
module brtrace_regs
    import brtrace_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              st_active,
    input  logic              st_halt,
    input  logic [AW-1:0]     st_off,
    output logic              ctrl_wr,
    output logic              ptr_wr,
    output logic              c_arm,
    output logic              c_use_start,
    output logic              c_use_stop,
    output logic              c_hof,
    output logic [ADDR_W-1:0] c_start,
    output logic [ADDR_W-1:0] c_stop,
    output logic [AW-1:0]     c_base,
    output logic [AW-1:0]     c_mask
);

    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] size_eff;

    assign ctrl_wr = cfg_we && (cfg_addr == REG_CTRL);
    assign ptr_wr  = cfg_we && (cfg_addr == REG_PTR);

    // Register storage updated on configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_arm       <= 1'b0;
            c_use_start <= 1'b0;
            c_use_stop  <= 1'b0;
            c_hof       <= 1'b0;
            size_q      <= '0;
            c_start     <= '0;
            c_stop      <= '0;
            c_base      <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL: begin
                    c_arm       <= cfg_wdata[CB_ARM];
                    c_use_start <= cfg_wdata[CB_USE_START];
                    c_use_stop  <= cfg_wdata[CB_USE_STOP];
                    c_hof       <= cfg_wdata[CB_HOF];
                    size_q      <= cfg_wdata[CB_SIZE_LO +: SIZE_W];
                end
                REG_START: c_start <= cfg_wdata[WORD_W-1:1];
                REG_STOP:  c_stop  <= cfg_wdata[WORD_W-1:1];
                REG_BASE:  c_base  <= cfg_wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    // Clamp the size field and turn it into a wrap mask.
    always_comb begin
        if (size_q == '0 || int'(size_q) > AW)
            size_eff = SIZE_W'(AW);
        else
            size_eff = size_q;
        c_mask = ~({AW{1'b1}} << size_eff);
    end

    // Read-back mux for the register port.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_CTRL: begin
                cfg_rdata[CB_ARM]                 = c_arm;
                cfg_rdata[CB_USE_START]           = c_use_start;
                cfg_rdata[CB_USE_STOP]            = c_use_stop;
                cfg_rdata[CB_HOF]                 = c_hof;
                cfg_rdata[CB_SIZE_LO +: SIZE_W]   = size_q;
                cfg_rdata[CB_ACTIVE]              = st_active;
                cfg_rdata[CB_HALT]                = st_halt;
            end
            REG_START: cfg_rdata = {c_start, 1'b0};
            REG_STOP:  cfg_rdata = {c_stop, 1'b0};
            REG_BASE:  cfg_rdata[AW-1:0] = c_base;
            REG_PTR:   cfg_rdata[AW-1:0] = st_off;
            default:   cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/brtrace_detect.sv
// Module: discontinuity detector with start/stop gating.
// Tracks the last qualified address and emits a source/target pair whenever
// the sequential flag drops while recording. Assumes the address is valid only
// with its enable and never while lockup is high. CTRL writes take priority
// over comparator matches in the same cycle.
module brtrace_detect
    import brtrace_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ex_addr,
    input  logic              ex_addr_en,
    input  logic              ex_seq,
    input  logic              core_lockup,
    input  logic              core_nonins,
    input  logic              ctrl_wr,
    input  logic              new_arm,
    input  logic              new_use_start,
    input  logic              c_arm,
    input  logic              c_use_start,
    input  logic              c_use_stop,
    input  logic [ADDR_W-1:0] c_start,
    input  logic [ADDR_W-1:0] c_stop,
    output logic              push,
    output pair_t             push_pair,
    output logic              active
);

    logic [ADDR_W-1:0] last_addr;
    logic              have_prev;
    logic              first_pend;
    logic              qual;
    logic              start_hit;
    logic              stop_hit;

    assign qual      = ex_addr_en && !core_lockup;
    assign start_hit = qual && c_arm && c_use_start && (ex_addr == c_start);
    assign stop_hit  = qual && c_use_stop && (ex_addr == c_stop);
    assign push      = qual && !ex_seq && !core_nonins && have_prev && active;

    assign push_pair.src   = last_addr;
    assign push_pair.dst   = ex_addr;
    assign push_pair.first = first_pend;

    // Remember the most recent qualified address as the next possible source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            have_prev <= 1'b0;
        end else if (qual) begin
            last_addr <= ex_addr;
            have_prev <= 1'b1;
        end
    end

    // Recording state and first-record marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            first_pend <= 1'b0;
        end else if (ctrl_wr) begin
            active     <= new_arm && !new_use_start;
            first_pend <= 1'b1;
        end else begin
            if (push)
                first_pend <= 1'b0;
            if (stop_hit)
                active <= 1'b0;
            else if (start_hit && !active) begin
                active     <= 1'b1;
                first_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/brtrace_pairq.sv
// Module: small FIFO of captured pairs between detector and RAM writer.
// A push arriving while the FIFO is full is dropped. DEPTH must be a power of
// two, at least 2.
module brtrace_pairq
    import brtrace_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  pair_t push_pair,
    input  logic  pop,
    input  logic  flush,
    output logic  valid,
    output logic  full,
    output pair_t head
);

    localparam int PW = $clog2(DEPTH);

    pair_t         mem [DEPTH];
    logic [PW-1:0] rd_ix;
    logic [PW-1:0] wr_ix;
    logic [PW:0]   cnt;
    logic          do_push;
    logic          do_pop;

    assign valid   = (cnt != '0);
    assign full    = (cnt == (PW+1)'(DEPTH));
    assign head    = mem[rd_ix];
    assign do_push = push && !full;
    assign do_pop  = pop && valid;

    // Storage array written at the tail.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ix] <= push_pair;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ix <= '0;
            wr_ix <= '0;
            cnt   <= '0;
        end else begin
            if (do_push)
                wr_ix <= wr_ix + 1'b1;
            if (do_pop)
                rd_ix <= rd_ix + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/brtrace_writer.sv
// Module: serialises pairs into two RAM writes and owns the write offset and
// halt request. Outputs are registered. Assumes the mask is 2^n-1. In
// stop-on-full mode the last-slot write is the final one until a CTRL write.
module brtrace_writer
    import brtrace_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  pair_t             q_head,
    output logic              q_pop,
    input  logic              ctrl_wr,
    input  logic              ptr_wr,
    input  logic [AW-1:0]     ptr_val,
    input  logic              c_hof,
    input  logic [AW-1:0]     c_base,
    input  logic [AW-1:0]     c_mask,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic [AW-1:0]     off,
    output logic              halt
);

    logic              phase;
    logic [ADDR_W-1:0] dst_hold;
    logic              last_q;
    logic              stop_full;
    logic              issue_dst;
    logic              issue_src;
    logic              issue;
    logic [WORD_W-1:0] word_nx;

    assign stop_full = c_hof && (halt || (ram_we && last_q));
    assign issue_dst = phase && !stop_full;
    assign issue_src = !phase && q_valid && !stop_full;
    assign issue     = issue_dst || issue_src;
    assign q_pop     = issue_src && !ctrl_wr;
    assign word_nx   = issue_dst ? {dst_hold, 1'b0} : {q_head.src, q_head.first};

    // Word sequencing: source first, target on the following write.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr) begin
            phase    <= 1'b0;
            dst_hold <= '0;
        end else if (issue_src) begin
            phase    <= 1'b1;
            dst_hold <= q_head.dst;
        end else if (issue_dst) begin
            phase    <= 1'b0;
        end
    end

    // Registered RAM port and offset stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_waddr <= '0;
            ram_wdata <= '0;
            last_q    <= 1'b0;
            off       <= '0;
        end else begin
            ram_we <= issue && !ctrl_wr;
            if (issue && !ctrl_wr) begin
                ram_waddr <= c_base + off;
                ram_wdata <= word_nx;
                last_q    <= (off == c_mask);
            end
            if (ptr_wr)
                off <= ptr_val & c_mask;
            else if (issue && !ctrl_wr)
                off <= (off + 1'b1) & c_mask;
        end
    end

    // Sticky halt request raised one cycle after the last-slot write.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr)
            halt <= 1'b0;
        else if (c_hof && ram_we && last_q)
            halt <= 1'b1;
    end

endmodule

// File: rtl/brtrace_rec.sv
// Module: top of the branch trace recorder. Connects the register block,
// detector, pair queue and RAM writer. Single clock, synchronous active-low
// reset. The trace RAM sits outside and takes one word per write strobe.
module brtrace_rec
    import brtrace_pkg::*;
#(
    parameter int AW     = 10,
    parameter int QDEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [30:0]       ex_addr,
    input  logic              ex_addr_en,
    input  logic              ex_seq,
    input  logic              core_lockup,
    input  logic              core_nonins,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [31:0]       ram_wdata,
    output logic              halt_req
);

    logic              ctrl_wr;
    logic              ptr_wr;
    logic              cfg_arm;
    logic              cfg_use_start;
    logic              cfg_use_stop;
    logic              cfg_hof;
    logic [ADDR_W-1:0] cfg_start;
    logic [ADDR_W-1:0] cfg_stop;
    logic [AW-1:0]     cfg_base;
    logic [AW-1:0]     cfg_mask;
    logic              rec_active;
    logic              q_push;
    pair_t             q_in;
    logic              q_pop;
    logic              q_valid;
    logic              q_full;
    pair_t             q_head;
    logic [AW-1:0]     wr_off;

    brtrace_regs #(.AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .st_active   (rec_active),
        .st_halt     (halt_req),
        .st_off      (wr_off),
        .ctrl_wr     (ctrl_wr),
        .ptr_wr      (ptr_wr),
        .c_arm       (cfg_arm),
        .c_use_start (cfg_use_start),
        .c_use_stop  (cfg_use_stop),
        .c_hof       (cfg_hof),
        .c_start     (cfg_start),
        .c_stop      (cfg_stop),
        .c_base      (cfg_base),
        .c_mask      (cfg_mask)
    );

    brtrace_detect u_det (
        .clk           (clk),
        .rst_n         (rst_n),
        .ex_addr       (ex_addr),
        .ex_addr_en    (ex_addr_en),
        .ex_seq        (ex_seq),
        .core_lockup   (core_lockup),
        .core_nonins   (core_nonins),
        .ctrl_wr       (ctrl_wr),
        .new_arm       (cfg_wdata[CB_ARM]),
        .new_use_start (cfg_wdata[CB_USE_START]),
        .c_arm         (cfg_arm),
        .c_use_start   (cfg_use_start),
        .c_use_stop    (cfg_use_stop),
        .c_start       (cfg_start),
        .c_stop        (cfg_stop),
        .push          (q_push),
        .push_pair     (q_in),
        .active        (rec_active)
    );

    brtrace_pairq #(.DEPTH(QDEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_pair (q_in),
        .pop       (q_pop),
        .flush     (ctrl_wr),
        .valid     (q_valid),
        .full      (q_full),
        .head      (q_head)
    );

    brtrace_writer #(.AW(AW)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_valid   (q_valid),
        .q_head    (q_head),
        .q_pop     (q_pop),
        .ctrl_wr   (ctrl_wr),
        .ptr_wr    (ptr_wr),
        .ptr_val   (cfg_wdata[AW-1:0]),
        .c_hof     (cfg_hof),
        .c_base    (cfg_base),
        .c_mask    (cfg_mask),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .off       (wr_off),
        .halt      (halt_req)
    );

endmodule

// File: rtl/brtrace_chk.sv
// Module: property checker for the recorder, bound to the top module.
module brtrace_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ram_we,
    input logic [31:0] ram_wdata,
    input logic        halt_req,
    input logic        hof,
    input logic        ctrl_wr,
    input logic        q_push,
    input logic        ex_addr_en,
    input logic        ex_seq,
    input logic        core_lockup,
    input logic        core_nonins
);

    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ram_we && !halt_req));

    // R3, R4, R5: a pair is only captured on a qualified, non-sequential cycle
    a_r3_push_gate: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> (ex_addr_en && !ex_seq && !core_lockup && !core_nonins));

    // R8: a marked source word is followed at once by an unmarked target word
    a_r8_first_then_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_wdata[0] && !hof && !ctrl_wr) |=> (ram_we && !ram_wdata[0]));

    // R10: no writes while halted in stop-on-full mode
    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && hof) |-> !ram_we);

    // R10: halt request is sticky until a CTRL write
    a_r10_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !ctrl_wr) |=> halt_req);

    // R10: halt never rises with the mode off
    a_r10_no_halt_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!hof && !halt_req) |=> !halt_req);

endmodule

bind brtrace_rec brtrace_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ram_we      (ram_we),
    .ram_wdata   (ram_wdata),
    .halt_req    (halt_req),
    .hof         (cfg_hof),
    .ctrl_wr     (ctrl_wr),
    .q_push      (q_push),
    .ex_addr_en  (ex_addr_en),
    .ex_seq      (ex_seq),
    .core_lockup (core_lockup),
    .core_nonins (core_nonins)
);

// File: tb/sim_brtrace_rec.sv
module sim_brtrace_rec;

    localparam int PERIOD = 10;
    localparam int AW     = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [30:0]   ex_addr = '0;
    logic          ex_addr_en = 1'b0;
    logic          ex_seq = 1'b1;
    logic          core_lockup = 1'b0;
    logic          core_nonins = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [31:0]   ram_wdata;
    logic          halt_req;

    int n_chk = 0;
    int n_bad = 0;
    int nlog = 0;
    logic [AW-1:0] log_a [64];
    logic [31:0]   log_d [64];

    always #(PERIOD/2) clk = ~clk;

    brtrace_rec #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ex_addr(ex_addr), .ex_addr_en(ex_addr_en),
        .ex_seq(ex_seq), .core_lockup(core_lockup), .core_nonins(core_nonins),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .ram_wdata(ram_wdata), .halt_req(halt_req)
    );

    // RAM write logger, sampled a quarter period after the edge
    always @(posedge clk) begin
        #(PERIOD/4);
        if (ram_we && nlog < 64) begin
            log_a[nlog] = ram_waddr;
            log_d[nlog] = ram_wdata;
            nlog = nlog + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic logic [31:0] ctrlw(input bit arm, input bit us, input bit up,
                                          input bit hof, input logic [4:0] sz);
        return {23'b0, sz, hof, up, us, arm};
    endfunction

    task automatic cyc(input logic [30:0] a, input bit en, input bit sq,
                       input bit lk = 0, input bit ni = 0);
        @(negedge clk);
        ex_addr = a; ex_addr_en = en; ex_seq = sq; core_lockup = lk; core_nonins = ni;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        ex_addr_en = 1'b0; ex_seq = 1'b1; core_lockup = 1'b0; core_nonins = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] ctrl, input logic [AW-1:0] base);
        reg_wr(3'd3, 32'(base));
        reg_wr(3'd4, 32'd0);
        reg_wr(3'd0, ctrl);
        nlog = 0;
    endtask

    task automatic chk_word(input string req, input int i, input logic [AW-1:0] a,
                            input logic [30:0] ad, input bit mk);
        chk(req, 32'(log_a[i]), 32'(a));
        chk(req, log_d[i], {ad, mk});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 ram_we", 32'(ram_we), 0);
        chk("R1 halt", 32'(halt_req), 0);
        reg_rd(3'd4, d); chk("R1 offset", d, 0);
        reg_rd(3'd0, d); chk("R1 active", 32'(d[16]), 0);
        chk("R1 no writes", nlog, 0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        setup(ctrlw(1, 0, 0, 0, 0), 10'h010);
        cyc(31'h100, 1, 1); cyc(31'h101, 1, 1); cyc(31'h102, 1, 1);
        cyc(31'h200, 1, 0); cyc(31'h201, 1, 1);
        cyc(31'h7777, 0, 0);       // R3: unqualified, must be ignored
        cyc(31'h300, 1, 0);
        idle(6);
        chk("R2 count", nlog, 4);
        chk_word("R2 R8 src first", 0, 10'h010, 31'h102, 1);
        chk_word("R2 dst", 1, 10'h011, 31'h200, 0);
        chk_word("R3 R8 src after en-low", 2, 10'h012, 31'h201, 0);
        chk_word("R2 dst2", 3, 10'h013, 31'h300, 0);
        reg_rd(3'd4, d); chk("R11 offset readback", d, 4);
    endtask

    task automatic t_lockup;
        setup(ctrlw(1, 0, 0, 0, 0), 10'h0);
        cyc(31'h600, 1, 1);
        cyc(31'h610, 1, 0, 1, 0);  // R4: lockup
        cyc(31'h700, 1, 0);
        idle(6);
        chk("R4 count", nlog, 2);
        chk_word("R4 src", 0, 10'h000, 31'h600, 1);
        chk_word("R4 dst", 1, 10'h001, 31'h700, 0);
    endtask

    task automatic t_nonins;
        setup(ctrlw(1, 0, 0, 0, 0), 10'h0);
        cyc(31'h800, 1, 1);
        cyc(31'h900, 1, 0, 0, 1);  // R5: suppressed but tracked
        cyc(31'hA00, 1, 0);
        idle(6);
        chk("R5 count", nlog, 2);
        chk_word("R5 src", 0, 10'h000, 31'h900, 1);
        chk_word("R5 dst", 1, 10'h001, 31'hA00, 0);
    endtask

    task automatic t_start;
        logic [31:0] d;
        reg_wr(3'd1, {31'h1000, 1'b0});
        setup(ctrlw(1, 1, 0, 0, 0), 10'h0);
        cyc(31'h50, 1, 1); cyc(31'h60, 1, 0);
        idle(2);
        reg_rd(3'd0, d); chk("R6 inactive before match", 32'(d[16]), 0);
        cyc(31'h1000, 1, 0);       // branch onto start: not recorded
        cyc(31'h1001, 1, 1); cyc(31'h1100, 1, 0);
        idle(6);
        reg_rd(3'd0, d); chk("R6 active after match", 32'(d[16]), 1);
        chk("R6 count", nlog, 2);
        chk_word("R6 R8 src", 0, 10'h000, 31'h1001, 1);
        chk_word("R6 dst", 1, 10'h001, 31'h1100, 0);
        reg_rd(3'd1, d); chk("R11 start readback", d, 32'h2000);
    endtask

    task automatic t_stop;
        logic [31:0] d;
        reg_wr(3'd2, {31'h2000, 1'b0});
        setup(ctrlw(1, 0, 1, 0, 0), 10'h0);
        cyc(31'h1F00, 1, 1); cyc(31'h2000, 1, 0);
        cyc(31'h2001, 1, 1); cyc(31'h2100, 1, 0);
        idle(6);
        chk("R7 count", nlog, 2);
        chk_word("R7 src", 0, 10'h000, 31'h1F00, 1);
        chk_word("R7 dst at stop", 1, 10'h001, 31'h2000, 0);
        reg_rd(3'd0, d); chk("R7 inactive", 32'(d[16]), 0);
    endtask

    task automatic three_pairs;
        cyc(31'h10, 1, 1); cyc(31'h20, 1, 0);
        cyc(31'h21, 1, 1); cyc(31'h30, 1, 0);
        cyc(31'h31, 1, 1); cyc(31'h40, 1, 0);
        idle(8);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        setup(ctrlw(1, 0, 0, 0, 5'd2), 10'h3FE);
        three_pairs();
        chk("R9 count", nlog, 6);
        chk_word("R9 w0", 0, 10'h3FE, 31'h10, 1);
        chk_word("R9 w1", 1, 10'h3FF, 31'h20, 0);
        chk_word("R9 w2 base wrap", 2, 10'h000, 31'h21, 0);
        chk_word("R9 w3", 3, 10'h001, 31'h30, 0);
        chk_word("R9 w4 window wrap", 4, 10'h3FE, 31'h31, 0);
        chk_word("R9 w5", 5, 10'h3FF, 31'h40, 0);
        chk("R10 no halt when off", 32'(halt_req), 0);
        reg_rd(3'd4, d); chk("R9 offset", d, 2);
    endtask

    task automatic t_full;
        logic [31:0] d;
        setup(ctrlw(1, 0, 0, 1, 5'd2), 10'h0);
        three_pairs();
        chk("R10 count", nlog, 4);
        chk_word("R10 last", 3, 10'h003, 31'h30, 0);
        chk("R10 halt", 32'(halt_req), 1);
        reg_rd(3'd0, d); chk("R11 halt readback", 32'(d[17]), 1);
        reg_wr(3'd0, 32'd0);
        #1 chk("R11 halt cleared", 32'(halt_req), 0);
    endtask

    task automatic t_burst;
        setup(ctrlw(1, 0, 0, 0, 0), 10'h0);
        cyc(31'hA0, 1, 1); cyc(31'hB0, 1, 0); cyc(31'hC0, 1, 0); cyc(31'hD0, 1, 0);
        idle(10);
        chk("R12 count", nlog, 6);
        chk_word("R12 p0s", 0, 10'h000, 31'hA0, 1);
        chk_word("R12 p0d", 1, 10'h001, 31'hB0, 0);
        chk_word("R12 p1s", 2, 10'h002, 31'hB0, 0);
        chk_word("R12 p1d", 3, 10'h003, 31'hC0, 0);
        chk_word("R12 p2s", 4, 10'h004, 31'hC0, 0);
        chk_word("R12 p2d", 5, 10'h005, 31'hD0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_lockup();
        t_nonins();
        t_start();
        t_stop();
        t_wrap();
        t_full();
        t_burst();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule